// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address by reading translation descriptors from memory. A caller presents an address together with the base of the first-level table, which must be aligned to 16 KB. The walker then fetches the first-level descriptor. That entry either maps a whole 1 MB region at once, or it names a second-level table. The second-level entry maps either a 64 KB page or a 4 KB page.

Descriptors come back over a simple memory read port, with a variable delay. A 2-bit type field in each descriptor chooses the next step. Type values that do not describe a valid mapping end the walk with a fault. Only one walk is in progress at a time. Each walk finishes with a single-cycle response that carries the physical address and the size of the region that matched, or carries a fault.

Top module: `xlate_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A `req_valid` seen while `req_ready` is low starts no walk, causes no memory read and produces no response.
- R2: The first read is at address {`tbl_base`, `req_vaddr[31:20]`, 2'b00}. `tbl_base` holds address bits 31:14 of the first-level table.
- R3: A first-level descriptor of type 2'b10 (bits 1:0) ends the walk after one read. It gives physical address {desc[31:20], va[19:0]} and `rsp_kind` 0.
- R4: A first-level descriptor of type 2'b01 starts a second read, at address {desc[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor of type 2'b01 gives physical address {desc[31:16], va[15:0]} and `rsp_kind` 1.
- R6: A second-level descriptor of type 2'b10 gives physical address {desc[31:12], va[11:0]} and `rsp_kind` 2.
- R7: A descriptor of type 2'b00 or 2'b11 at either level ends the walk with no further read. The response then has `rsp_fault` high, `rsp_paddr` zero and `rsp_kind` 0.
- R8: Once `mem_rd_en` is raised, it stays high with a stable, word-aligned `mem_addr` until `mem_rvalid` arrives.
- R9: `rsp_valid` is a one-cycle pulse. `req_ready` is high in the cycle after it.
- R10: After reset, and also after a reset that interrupts a walk, `req_ready` is high and both `mem_rd_en` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 18 | First-level table base, address bits 31:14 |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_rd_en | output | 1 | Descriptor read request, held until data returns |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |
| rsp_valid | output | 1 | Walk result pulse |
| rsp_fault | output | 1 | Walk ended on an invalid descriptor |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_kind | output | 2 | 0 = 1 MB region, 1 = 64 KB page, 2 = 4 KB page |

## Verification
The assertions check the protocol rules on every cycle. These are the shape of the first descriptor address at the moment a request is accepted, the holding of the read request until data arrives, word alignment, the single-cycle response followed by readiness, and the zeroed result on a fault. Address arithmetic at each level, the choice of region size and the number of memory reads per walk can only be shown by the bench's scenarios. Those scenarios run walks against a modelled table memory with varied read delays, a request made while busy, and a reset in the middle of a walk.

// File: rtl/xw_pkg.sv
// Shared types for the translation walker.
// Assumes descriptors carry a 2-bit type in bits [1:0].
package xw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L2_READ,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        ACT_FAULT,
        ACT_DESCEND,
        ACT_MAP
    } desc_act_e;

    localparam logic [1:0] L1_TYPE_COARSE  = 2'b01;
    localparam logic [1:0] L1_TYPE_SECTION = 2'b10;
    localparam logic [1:0] L2_TYPE_LARGE   = 2'b01;
    localparam logic [1:0] L2_TYPE_SMALL   = 2'b10;

    localparam logic [1:0] KIND_SECTION = 2'd0;
    localparam logic [1:0] KIND_LARGE   = 2'd1;
    localparam logic [1:0] KIND_SMALL   = 2'd2;

endpackage

// File: rtl/xw_desc_addr.sv
// Descriptor address former.
// Selects the first-level or the second-level descriptor address for the
// current walk step. Assumes word-sized descriptors and tables that are
// naturally aligned.
module xw_desc_addr #(
    parameter int ADDR_W      = 32,
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int SMALL_OFF_W = 12
) (
    input  logic                              sel_l2,
    input  logic [ADDR_W-1:0]                 va,
    input  logic [ADDR_W-L1_IDX_W-3:0]        tbl_base,
    input  logic [ADDR_W-L2_IDX_W-3:0]        l2_base,
    output logic [ADDR_W-1:0]                 desc_addr
);
    localparam int SEC_OFF_W = L2_IDX_W + SMALL_OFF_W;

    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;
    logic              va_unused;

    assign va_unused = ^va[SMALL_OFF_W-1:0];

    // Join the table base with the index for each level.
    always_comb begin
        l1_addr = {tbl_base, va[ADDR_W-1 -: L1_IDX_W], 2'b00};
        l2_addr = {l2_base, va[SEC_OFF_W-1 -: L2_IDX_W], 2'b00};
    end

    // Pick the address for the level being read.
    always_comb begin
        desc_addr = sel_l2 ? l2_addr : l1_addr;
    end

endmodule

// File: rtl/xw_desc_decode.sv
// Descriptor decoder.
// Interprets a returned descriptor at either level. It yields the next action,
// the mapped physical address with its region kind, and the next table base.
// Purely combinational. Assumes the type field is in bits [1:0].
module xw_desc_decode
    import xw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int L2_IDX_W    = 8,
    parameter int SMALL_OFF_W = 12,
    parameter int LARGE_OFF_W = 16
) (
    input  logic                       is_l2,
    input  logic [ADDR_W-1:0]          desc,
    input  logic [ADDR_W-1:0]          va,
    output desc_act_e                  act,
    output logic [ADDR_W-1:0]          map_pa,
    output logic [1:0]                 map_kind,
    output logic [ADDR_W-L2_IDX_W-3:0] next_base
);
    localparam int SEC_OFF_W = L2_IDX_W + SMALL_OFF_W;
    localparam int L2B_W     = ADDR_W - L2_IDX_W - 2;

    logic [1:0] dtype;
    logic       desc_unused;
    logic       va_unused;

    assign dtype       = desc[1:0];
    assign desc_unused = ^desc[ADDR_W-L2B_W-1:2];
    assign va_unused   = ^va[ADDR_W-1:SEC_OFF_W];

    // Second-level table base taken from the upper descriptor bits.
    always_comb begin
        next_base = desc[ADDR_W-1 -: L2B_W];
    end

    // Decide the action and the mapped address from level and type.
    always_comb begin
        act      = ACT_FAULT;
        map_pa   = '0;
        map_kind = KIND_SECTION;
        if (!is_l2) begin
            case (dtype)
                L1_TYPE_SECTION: begin
                    act      = ACT_MAP;
                    map_pa   = {desc[ADDR_W-1:SEC_OFF_W], va[SEC_OFF_W-1:0]};
                    map_kind = KIND_SECTION;
                end
                L1_TYPE_COARSE: begin
                    act = ACT_DESCEND;
                end
                default: begin
                    act = ACT_FAULT;
                end
            endcase
        end else begin
            case (dtype)
                L2_TYPE_LARGE: begin
                    act      = ACT_MAP;
                    map_pa   = {desc[ADDR_W-1:LARGE_OFF_W], va[LARGE_OFF_W-1:0]};
                    map_kind = KIND_LARGE;
                end
                L2_TYPE_SMALL: begin
                    act      = ACT_MAP;
                    map_pa   = {desc[ADDR_W-1:SMALL_OFF_W], va[SMALL_OFF_W-1:0]};
                    map_kind = KIND_SMALL;
                end
                default: begin
                    act = ACT_FAULT;
                end
            endcase
        end
    end

endmodule

// File: rtl/xw_walk_ctrl.sv
// Walk sequencer.
// Holds the walk state and the request context: the address, the table base
// and the second-level base. It also holds the result. A request is taken
// only in IDLE. Each read state waits for mem_rvalid and then follows the
// decoded action.
module xw_walk_ctrl
    import xw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int L1_IDX_W = 12,
    parameter int L2_IDX_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_vaddr,
    input  logic [ADDR_W-L1_IDX_W-3:0]        tbl_base,
    input  logic                              mem_rvalid,
    input  desc_act_e                         act,
    input  logic [ADDR_W-1:0]                 map_pa,
    input  logic [1:0]                        map_kind,
    input  logic [ADDR_W-L2_IDX_W-3:0]        next_base,
    output walk_state_e                       state,
    output logic [ADDR_W-1:0]                 va_q,
    output logic [ADDR_W-L1_IDX_W-3:0]        base_q,
    output logic [ADDR_W-L2_IDX_W-3:0]        l2b_q,
    output logic [ADDR_W-1:0]                 pa_q,
    output logic [1:0]                        kind_q
);

    // Step the walk and capture context and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            base_q <= '0;
            l2b_q  <= '0;
            pa_q   <= '0;
            kind_q <= KIND_SECTION;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        base_q <= tbl_base;
                        state  <= ST_L1_READ;
                    end
                end
                ST_L1_READ: begin
                    if (mem_rvalid) begin
                        case (act)
                            ACT_MAP: begin
                                pa_q   <= map_pa;
                                kind_q <= map_kind;
                                state  <= ST_DONE;
                            end
                            ACT_DESCEND: begin
                                l2b_q <= next_base;
                                state <= ST_L2_READ;
                            end
                            default: begin
                                pa_q   <= '0;
                                kind_q <= KIND_SECTION;
                                state  <= ST_FAULT;
                            end
                        endcase
                    end
                end
                ST_L2_READ: begin
                    if (mem_rvalid) begin
                        if (act == ACT_MAP) begin
                            pa_q   <= map_pa;
                            kind_q <= map_kind;
                            state  <= ST_DONE;
                        end else begin
                            pa_q   <= '0;
                            kind_q <= KIND_SECTION;
                            state  <= ST_FAULT;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xlate_walker.sv
// Two-level translation table walker, top level.
// Reads descriptors over a hold-until-valid read port and returns a one-cycle
// result. Assumes the first-level table is 16 KB aligned and that the memory
// returns exactly one mem_rvalid per held request.
module xlate_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int L1_IDX_W    = 12,
    parameter int L2_IDX_W    = 8,
    parameter int SMALL_OFF_W = 12,
    parameter int LARGE_OFF_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic [ADDR_W-L1_IDX_W-3:0] tbl_base,
    output logic                       req_ready,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic                       mem_rvalid,
    input  logic [ADDR_W-1:0]          mem_rdata,
    output logic                       rsp_valid,
    output logic                       rsp_fault,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic [1:0]                 rsp_kind
);
    localparam int BASE_W = ADDR_W - L1_IDX_W - 2;
    localparam int L2B_W  = ADDR_W - L2_IDX_W - 2;

    walk_state_e       state;
    logic [ADDR_W-1:0] va_q;
    logic [BASE_W-1:0] base_q;
    logic [L2B_W-1:0]  l2b_q;
    logic [ADDR_W-1:0] pa_q;
    logic [1:0]        kind_q;
    desc_act_e         act;
    logic [ADDR_W-1:0] map_pa;
    logic [1:0]        map_kind;
    logic [L2B_W-1:0]  next_base;
    logic              in_l2;

    assign in_l2 = (state == ST_L2_READ);

    xw_walk_ctrl #(
        .ADDR_W   (ADDR_W),
        .L1_IDX_W (L1_IDX_W),
        .L2_IDX_W (L2_IDX_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .tbl_base   (tbl_base),
        .mem_rvalid (mem_rvalid),
        .act        (act),
        .map_pa     (map_pa),
        .map_kind   (map_kind),
        .next_base  (next_base),
        .state      (state),
        .va_q       (va_q),
        .base_q     (base_q),
        .l2b_q      (l2b_q),
        .pa_q       (pa_q),
        .kind_q     (kind_q)
    );

    xw_desc_addr #(
        .ADDR_W      (ADDR_W),
        .L1_IDX_W    (L1_IDX_W),
        .L2_IDX_W    (L2_IDX_W),
        .SMALL_OFF_W (SMALL_OFF_W)
    ) addr_i (
        .sel_l2    (in_l2),
        .va        (va_q),
        .tbl_base  (base_q),
        .l2_base   (l2b_q),
        .desc_addr (mem_addr)
    );

    xw_desc_decode #(
        .ADDR_W      (ADDR_W),
        .L2_IDX_W    (L2_IDX_W),
        .SMALL_OFF_W (SMALL_OFF_W),
        .LARGE_OFF_W (LARGE_OFF_W)
    ) dec_i (
        .is_l2     (in_l2),
        .desc      (mem_rdata),
        .va        (va_q),
        .act       (act),
        .map_pa    (map_pa),
        .map_kind  (map_kind),
        .next_base (next_base)
    );

    // Port-level status derived from the walk state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_rd_en = (state == ST_L1_READ) || (state == ST_L2_READ);
        rsp_valid = (state == ST_DONE) || (state == ST_FAULT);
        rsp_fault = (state == ST_FAULT);
        rsp_paddr = pa_q;
        rsp_kind  = kind_q;
    end

endmodule

// File: rtl/xlate_walker_chk.sv
// Protocol checker for xlate_walker, attached through bind.
module xlate_walker_chk #(
    parameter int ADDR_W   = 32,
    parameter int L1_IDX_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [ADDR_W-1:0]          req_vaddr,
    input logic [ADDR_W-L1_IDX_W-3:0] tbl_base,
    input logic                       req_ready,
    input logic                       mem_rd_en,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic                       mem_rvalid,
    input logic                       rsp_valid,
    input logic                       rsp_fault,
    input logic [ADDR_W-1:0]          rsp_paddr,
    input logic [1:0]                 rsp_kind
);

    // R1
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || rsp_valid) |-> !req_ready);

    // R2
    l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en &&
            mem_addr == {$past(tbl_base), $past(req_vaddr[ADDR_W-1 -: L1_IDX_W]), 2'b00}));

    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_kind == 2'd0));

    // R8
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_addr)));

    // R8
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr[1:0] == 2'b00));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_rd_en && !rsp_valid));

endmodule

bind xlate_walker xlate_walker_chk #(
    .ADDR_W   (ADDR_W),
    .L1_IDX_W (L1_IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .tbl_base   (tbl_base),
    .req_ready  (req_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .rsp_kind   (rsp_kind)
);

// File: tb/xlate_walker_tb_top.sv
// Self-checking bench for xlate_walker with a modelled descriptor memory.
module xlate_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [17:0] tbl_base = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_kind;

    int          checks = 0;
    int          errors = 0;
    logic [3:0]  lat_cfg = '0;
    logic [3:0]  lat_cnt;
    logic        rv_q;
    logic [31:0] rd_q;
    int          reads_total;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlate_walker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .tbl_base   (tbl_base),
        .req_ready  (req_ready),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_paddr  (rsp_paddr),
        .rsp_kind   (rsp_kind)
    );

    // Sparse table contents for the scenarios below.
    function automatic logic [31:0] table_word(input logic [31:0] a);
        case (a)
            32'h0008_048C: table_word = 32'hABC0_0002; // L1 section
            32'h0008_0010: table_word = 32'h0020_0401; // L1 coarse -> 0x200400
            32'h0020_040C: table_word = 32'h7777_7002; // L2 small
            32'h0020_0558: table_word = 32'h5555_0001; // L2 large
            32'h0008_0004: table_word = 32'hDEAD_BEE3; // L1 type 11
            32'h0020_0480: table_word = 32'h1234_5673; // L2 type 11
            32'h0010_C48C: table_word = 32'h0010_0002; // L1 section, second base
            default:       table_word = 32'h0000_0000;
        endcase
    endfunction

    // Memory model: answer a held read after lat_cfg extra cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            rv_q    <= 1'b0;
            rd_q    <= '0;
            lat_cnt <= '0;
        end else if (mem_rd_en && !rv_q) begin
            if (lat_cnt == lat_cfg) begin
                rv_q    <= 1'b1;
                rd_q    <= table_word(mem_addr);
                lat_cnt <= '0;
            end else begin
                lat_cnt <= lat_cnt + 4'd1;
            end
        end else begin
            rv_q    <= 1'b0;
            lat_cnt <= '0;
        end
    end
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;

    // Count descriptor reads that the walker consumes.
    initial reads_total = 0;
    always @(posedge clk) begin
        if (rst_n && rv_q && mem_rd_en) reads_total <= reads_total + 1;
    end

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Run one walk and collect its result.
    task automatic do_walk(input logic [31:0] va, input logic [17:0] base,
                           input logic [3:0] lat, output logic [31:0] pa,
                           output logic flt, output logic [1:0] kind,
                           output int nreads, output logic seen);
        int start;
        seen = 1'b0;
        pa = '0; flt = 1'b0; kind = '0;
        @(negedge clk);
        start     = reads_total;
        lat_cfg   = lat;
        req_valid = 1'b1;
        req_vaddr = va;
        tbl_base  = base;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (rsp_valid) begin
                seen = 1'b1;
                pa   = rsp_paddr;
                flt  = rsp_fault;
                kind = rsp_kind;
                break;
            end
            @(negedge clk);
        end
        nreads = reads_total - start;
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [17:0] base;
        logic [3:0]  lat;
        logic [31:0] pa;
        logic        flt;
        logic [1:0]  kind;
        logic [1:0]  reads;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 18'h20, 4'd1, 32'hABC4_5678, 1'b0, 2'd0, 2'd1}, // R3
        '{32'h0040_3ABC, 18'h20, 4'd0, 32'h7777_7ABC, 1'b0, 2'd2, 2'd2}, // R4 R6
        '{32'h0045_6DEF, 18'h20, 4'd3, 32'h5555_6DEF, 1'b0, 2'd1, 2'd2}, // R4 R5
        '{32'hFFF0_0000, 18'h20, 4'd2, 32'h0000_0000, 1'b1, 2'd0, 2'd1}, // R7 L1 00
        '{32'h0010_0000, 18'h20, 4'd0, 32'h0000_0000, 1'b1, 2'd0, 2'd1}, // R7 L1 11
        '{32'h0041_0000, 18'h20, 4'd1, 32'h0000_0000, 1'b1, 2'd0, 2'd2}, // R7 L2 00
        '{32'h0042_0000, 18'h20, 4'd2, 32'h0000_0000, 1'b1, 2'd0, 2'd2}, // R7 L2 11
        '{32'h1234_5678, 18'h43, 4'd0, 32'h0014_5678, 1'b0, 2'd0, 2'd1}, // R2 other base
        '{32'h123F_FFFF, 18'h20, 4'd0, 32'hABCF_FFFF, 1'b0, 2'd0, 2'd1}  // R3 offset edge
    };

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] pa;
        logic        flt;
        logic [1:0]  kind;
        int          nr;
        logic        seen;
        string       tag;
        int          r0;
        logic        extra;

        repeat (3) @(negedge clk);
        // R10: reset state
        check32("R10", "ready in reset", {31'd0, req_ready}, 32'd1);
        check32("R10", "rd_en in reset", {31'd0, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R10", "ready after reset", {31'd0, req_ready}, 32'd1);
        check32("R10", "rsp after reset", {31'd0, rsp_valid}, 32'd0);

        // Table-driven walks
        for (int v = 0; v < NV; v++) begin
            do_walk(VECS[v].va, VECS[v].base, VECS[v].lat, pa, flt, kind, nr, seen);
            if (VECS[v].flt)             tag = "R7";
            else if (VECS[v].base != 18'h20) tag = "R2";
            else if (VECS[v].kind == 2'd0) tag = "R3";
            else if (VECS[v].kind == 2'd1) tag = "R5";
            else                           tag = "R6";
            check32(tag, "response seen", {31'd0, seen}, 32'd1);
            check32(tag, "fault", {31'd0, flt}, {31'd0, VECS[v].flt});
            check32(tag, "paddr", pa, VECS[v].pa);
            check32(tag, "kind", {30'd0, kind}, {30'd0, VECS[v].kind});
            check32((VECS[v].reads == 2'd2) ? "R4" : tag, "read count",
                    nr, {30'd0, VECS[v].reads});
            @(negedge clk);
            // R9: ready again after the pulse
            check32("R9", "ready after rsp", {31'd0, req_ready}, 32'd1);
        end

        // R1: request while busy is ignored
        @(negedge clk);
        r0        = reads_total;
        lat_cfg   = 4'd3;
        req_valid = 1'b1;
        req_vaddr = 32'h0040_3ABC;
        tbl_base  = 18'h20;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check32("R1", "ready while busy", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b1;
        req_vaddr = 32'h1234_5678;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 1'b0;
        pa   = '0;
        for (int i = 0; i < 64; i++) begin
            if (rsp_valid) begin
                seen = 1'b1;
                pa   = rsp_paddr;
                break;
            end
            @(negedge clk);
        end
        check32("R1", "first walk result", pa, 32'h7777_7ABC);
        extra = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid || mem_rd_en) extra = 1'b1;
        end
        check32("R1", "no second walk", {31'd0, extra}, 32'd0);
        check32("R1", "reads for one walk", reads_total - r0, 32'd2);

        // R10: reset in the middle of a walk
        @(negedge clk);
        lat_cfg   = 4'd3;
        req_valid = 1'b1;
        req_vaddr = 32'h0045_6DEF;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R10", "ready after mid reset", {31'd0, req_ready}, 32'd1);
        check32("R10", "rd_en after mid reset", {31'd0, mem_rd_en}, 32'd0);
        check32("R10", "rsp after mid reset", {31'd0, rsp_valid}, 32'd0);
        do_walk(32'h1234_5678, 18'h20, 4'd0, pa, flt, kind, nr, seen);
        check32("R3", "walk after mid reset", pa, 32'hABC4_5678);

        finish_run();
    end

endmodule